// File: doc/BRIEF.md
# Iterative signed/unsigned integer divider

This block divides one 32-bit integer by another over a fixed run of clock cycles and sits beside the arithmetic unit of a processor's execute stage. A one-cycle start pulse on one of two inputs captures the operands: the first operand is the dividend and the second is the divisor. One start input selects two's-complement division and the other selects unsigned division. The block then computes one quotient bit per cycle with a restoring shift-and-subtract loop. It holds a busy flag high until the quotient and remainder are ready.

The surrounding logic writes the remainder into the upper half and the quotient into the lower half of its 64-bit result register pair. It uses the busy flag to hold back only those later instructions that touch that pair. The divider raises no exception. A zero divisor and the most-negative-by-minus-one case both finish in the usual time and return fixed patterns. For signed division, the block divides the operand magnitudes and then corrects the signs, so the quotient truncates toward zero.

Top module: `iter_divider`

## Requirements
- R1: After a synchronous active-high reset, `busy_o` is 0 and `quotient_o` and `remainder_o` are 0.
- R2: When the unit is idle and a start strobe is sampled at a clock edge, `busy_o` is 1 for exactly 32 cycles after that edge and then returns to 0. The results are valid in the first cycle in which `busy_o` is 0 again.
- R3: With `start_unsigned_i`, the operands are unsigned. The quotient is floor(dividend/divisor) and the remainder is dividend mod divisor.
- R4: With `start_signed_i`, the operands are two's complement. The quotient truncates toward zero and is negative exactly when the operand signs differ and the quotient is non-zero. The remainder has the sign of the dividend, and dividend = quotient*divisor + remainder.
- R5: A start strobe that arrives while `busy_o` is 1 is ignored. The running division ends at its original time with its original result, and no new division follows it.
- R6: A zero divisor completes in the normal 32 cycles and the remainder equals the dividend. The quotient is 0xFFFFFFFF, except for a signed division with a negative dividend, where it is 0x00000001.
- R7: A signed division of 0x80000000 by 0xFFFFFFFF completes with quotient 0x80000000 and remainder 0, and no other signal changes.
- R8: `quotient_o` and `remainder_o` keep their previous values while a division runs. After the division completes they hold its result until the next accepted start, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_signed_i | input | 1 | One-cycle strobe that starts a two's-complement division |
| start_unsigned_i | input | 1 | One-cycle strobe that starts an unsigned division |
| dividend_i | input | 32 | Dividend, sampled with the strobe |
| divisor_i | input | 32 | Divisor, sampled with the strobe |
| quotient_o | output | 32 | Quotient of the last completed division |
| remainder_o | output | 32 | Remainder of the last completed division |
| busy_o | output | 1 | High while a division is running |

## Verification
The assertions assume that the two start strobes are never high in the same cycle. They also assume that a strobe lasts one cycle when the unit accepts it. The bench drives exactly one strobe for one cycle per division, and it fires stray strobes only while `busy_o` is high, where they must be ignored. Operands come from a fixed-seed random source, mixed with zero divisors, most-negative dividends, minus-one divisors and operands of equal magnitude. The assertions check the 32-cycle busy window, that the outputs do not move while busy or while idle, and that the partial remainder stays below the divisor.

// File: rtl/div_pkg.sv
package div_pkg;
    localparam int unsigned DIV_WIDTH = 32;

    function automatic int unsigned count_bits(input int unsigned width);
        return $clog2(width + 1);
    endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         is_signed_i,
    output logic [W-1:0] mag_dividend_o,
    output logic [W-1:0] mag_divisor_o,
    output logic         neg_quot_o,
    output logic         neg_rem_o
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg          = is_signed_i & dividend_i[W-1];
        b_neg          = is_signed_i & divisor_i[W-1];
        mag_dividend_o = a_neg ? (~dividend_i + 1'b1) : dividend_i;
        mag_divisor_o  = b_neg ? (~divisor_i + 1'b1) : divisor_i;
        neg_quot_o     = a_neg ^ b_neg;
        neg_rem_o      = a_neg;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0]   shifted;
    logic [W-1:0] diff;
    logic         fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        fits    = (shifted >= {1'b0, dvs_i});
        diff    = shifted[W-1:0] - dvs_i;
        rem_o   = fits ? diff : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    input  logic         neg_quot_i,
    input  logic         neg_rem_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    always_comb begin
        quo_o = neg_quot_i ? (~quo_i + 1'b1) : quo_i;
        rem_o = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
    parameter int unsigned W = div_pkg::DIV_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_signed_i,
    input  logic         start_unsigned_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         busy_o
);
    localparam int unsigned CW = div_pkg::count_bits(W);
    localparam logic [CW-1:0] ITER = CW'(W);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg_q;
        logic          neg_r;
        logic [W-1:0]  q_out;
        logic [W-1:0]  r_out;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [W-1:0] mag_a, mag_b, step_rem, step_quo, fix_quo, fix_rem;
    logic         prep_neg_q, prep_neg_r, accept;

    div_operand_prep #(.W(W)) i_prep (
        .dividend_i     (dividend_i),
        .divisor_i      (divisor_i),
        .is_signed_i    (start_signed_i),
        .mag_dividend_o (mag_a),
        .mag_divisor_o  (mag_b),
        .neg_quot_o     (prep_neg_q),
        .neg_rem_o      (prep_neg_r)
    );

    div_step #(.W(W)) i_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dvs_i (st_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    div_sign_fix #(.W(W)) i_fix (
        .quo_i      (step_quo),
        .rem_i      (step_rem),
        .neg_quot_i (st_q.neg_q),
        .neg_rem_i  (st_q.neg_r),
        .quo_o      (fix_quo),
        .rem_o      (fix_rem)
    );

    always_comb begin
        st_d   = st_q;
        accept = (start_signed_i | start_unsigned_i) & ~st_q.busy;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = ITER;
            st_d.rem   = '0;
            st_d.quo   = mag_a;
            st_d.dvs   = mag_b;
            st_d.neg_q = prep_neg_q;
            st_d.neg_r = prep_neg_r;
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy  = 1'b0;
                st_d.q_out = fix_quo;
                st_d.r_out = fix_rem;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quotient_o  = st_q.q_out;
    assign remainder_o = st_q.r_out;
    assign busy_o      = st_q.busy;

    // R2: an accepted strobe makes the unit busy in the next cycle
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (start_signed_i || start_unsigned_i)) |=> busy_o);

    // R2, R5: busy lasts until the iteration count runs out, strobes or not
    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && st_q.cnt != CW'(1)) |=> busy_o);

    // R2: the last iteration always releases busy
    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && st_q.cnt == CW'(1)) |=> !busy_o);

    // R8: results do not move before the final iteration
    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && st_q.cnt != CW'(1)) |=> ($stable(quotient_o) && $stable(remainder_o)));

    // R8: results hold while idle without a strobe
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_signed_i && !start_unsigned_i)
        |=> ($stable(quotient_o) && $stable(remainder_o)));

    // R3: restoring loop keeps the partial remainder below a non-zero divisor
    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && st_q.dvs != '0) |-> (st_q.rem < st_q.dvs));
endmodule

// File: tb/test_iter_divider.sv
module test_iter_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_signed_i = 1'b0;
    logic         start_unsigned_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quotient_o, remainder_o;
    logic         busy_o;

    int checks = 0;
    int fails  = 0;

    iter_divider #(.W(W)) i_iter_divider (
        .clk              (clk),
        .rst              (rst),
        .start_signed_i   (start_signed_i),
        .start_unsigned_i (start_unsigned_i),
        .dividend_i       (dividend_i),
        .divisor_i        (divisor_i),
        .quotient_o       (quotient_o),
        .remainder_o      (remainder_o),
        .busy_o           (busy_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] model(input logic sgn, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
        logic [W-1:0] q, r, ma, mb, uq, ur;
        logic sa, sb;
        sa = sgn & a[W-1];
        sb = sgn & b[W-1];
        if (b == '0) begin
            q = sa ? W'(1) : '1;
            r = a;
        end else begin
            ma = sa ? -a : a;
            mb = sb ? -b : b;
            uq = ma / mb;
            ur = ma % mb;
            q  = (sa ^ sb) ? -uq : uq;
            r  = sa ? -ur : ur;
        end
        return {r, q};
    endfunction

    task automatic run_div(input string req, input logic sgn, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic stray);
        logic [2*W-1:0] exp;
        logic [W-1:0] old_q, old_r;
        int busy_bad = 0;
        exp = model(sgn, a, b);
        @(negedge clk);
        old_q = quotient_o;
        old_r = remainder_o;
        dividend_i = a;
        divisor_i  = b;
        start_signed_i   = sgn;
        start_unsigned_i = ~sgn;
        @(negedge clk);
        start_signed_i   = 1'b0;
        start_unsigned_i = 1'b0;
        if (busy_o !== 1'b1) busy_bad++;
        for (int i = 0; i < W - 1; i++) begin
            if (stray && i == 10) begin
                dividend_i = $urandom;
                divisor_i  = $urandom;
                start_unsigned_i = 1'b1;
            end
            if (stray && i == 11) start_unsigned_i = 1'b0;
            @(negedge clk);
            if (busy_o !== 1'b1) busy_bad++;
            if (i == 20) begin
                check("R8 hold while busy q", quotient_o, old_q);
                check("R8 hold while busy r", remainder_o, old_r);
            end
        end
        @(negedge clk);
        check("R2 busy window", W'(busy_bad), '0);
        check("R2 busy released", W'(busy_o), '0);
        check({req, " quotient"}, quotient_o, exp[W-1:0]);
        check({req, " remainder"}, remainder_o, exp[2*W-1:W]);
        if (stray) begin
            @(negedge clk);
            check("R5 no follow-on division", W'(busy_o), '0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy reset", W'(busy_o), '0);
        check("R1 quotient reset", quotient_o, '0);
        check("R1 remainder reset", remainder_o, '0);

        run_div("R3", 1'b0, 32'd100, 32'd7, 1'b0);
        run_div("R3", 1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run_div("R3", 1'b0, 32'd5, 32'hFFFF_FFFF, 1'b0);
        run_div("R4", 1'b1, -32'sd7, 32'd2, 1'b0);
        run_div("R4", 1'b1, 32'd7, -32'sd2, 1'b0);
        run_div("R4", 1'b1, -32'sd7, -32'sd2, 1'b0);
        run_div("R4", 1'b1, -32'sd9, 32'd9, 1'b0);
        run_div("R6", 1'b0, 32'h1234_5678, 32'd0, 1'b0);
        run_div("R6", 1'b1, -32'sd5, 32'd0, 1'b0);
        run_div("R6", 1'b1, 32'd5, 32'd0, 1'b0);
        run_div("R7", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_div("R5", 1'b0, 32'd1000, 32'd3, 1'b1);

        // R8: outputs hold after completion while operands change
        begin
            logic [W-1:0] hq, hr;
            hq = quotient_o;
            hr = remainder_o;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                dividend_i = $urandom;
                divisor_i  = $urandom;
            end
            @(negedge clk);
            check("R8 hold idle q", quotient_o, hq);
            check("R8 hold idle r", remainder_o, hr);
        end

        for (int n = 0; n < 150; n++) begin
            logic sgn;
            logic [W-1:0] a, b;
            sgn = 1'($urandom);
            a = $urandom;
            b = $urandom;
            if (n % 4 == 1) b = b >> ($urandom % 32);
            if (n % 7 == 3) b = '0;
            run_div(sgn ? "R4" : "R3", sgn, a, b, (n % 10 == 5));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule